// File: doc/BRIEF.md
# One-Time-Programmable Configuration Shifter

This block holds the configuration word of a sensor front end and manages how that word is read from, and written into, a one-way fuse array over a two-wire serial link: a master clock and a data line. One operating mode is chosen in the first clock after power-on reset, from the levels of a few strap inputs. These are a digital flag for the programming supply, a flag for the higher fuse-burning supply, a power-save input and the serial data input. The mode then holds until the next reset.

There are four modes. In normal mode the working register simply reflects the fuses. In fuse-read mode the fuse contents are presented bit by bit on a serial output. In register-write mode bits are shifted in and change only the volatile working copy. In fuse-write mode the same shifting also burns each incoming 1 into the fuse array. A fuse can only go from 0 to 1. For that reason the offset, mode and error-mask parameters each exist as three copies that are XOR-combined, so each parameter can be reprogrammed up to three times. The combined parameters, the CRC seed and a decoded test selection are provided as outputs.

Top module: `cfg_shift_top`

## Requirements
- R1: While `rstN` is low, `opMode` is 0 (start), `cfgWord` is all zero, and `sdo` and `burnPulse` are low.
- R2: In the first clock after reset release the block leaves start and selects a mode, which then holds until reset. The mode is normal (`opMode`=1) when `progEn` is low or `psIn` is high. Otherwise it is fuse read (2) when `sdi` is high, fuse write (4) when `sdi` is low and `burnEn` is high, and register write (3) when both are low.
- R3: On leaving start, in every mode, `cfgWord` is loaded with the fuse array contents.
- R4: In register-write mode, the k-th rising edge of `sclk` (k = 0..51) stores `sdi` into `cfgWord[k]`. The fuse array is not changed.
- R5: Fuse-write mode behaves as R4 and also sets fuse bit k when `sdi` is 1. Fuse bits are never cleared by writing. `burnPulse` is high for one cycle for each 1 that is burned, and only in this mode.
- R6: In fuse-read mode, `sdo` shows `cfgWord[k]`, where k is the number of `sclk` rising edges seen so far. After 52 edges, and in every other mode, `sdo` is 0.
- R7: After 52 `sclk` rising edges, further edges change neither `cfgWord` nor the fuses. In normal mode `sclk` has no effect.
- R8: `offset`, `modeCfg` and `errMask` are the XOR of three sets. A set s (s = 0,1,2) starts at bit 14*s and holds offset in [7:0], mode in [11:8] and error mask in [13:12], relative to that start.
- R9: `crcSeed` is `cfgWord[45:42]`. `testSel` decodes `cfgWord[51:48]`: 1000 gives 1, 1001 gives 2, 1010 gives 3, and every other code gives 0 (normal operation).
- R10: Low `blankN` clears the fuse array to all zero. The fuse array keeps its contents across `rstN`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| blankN | input | 1 | Clears the fuse model to its unprogrammed state, active low |
| progEn | input | 1 | Programming supply detected |
| burnEn | input | 1 | Fuse-burning supply level detected |
| psIn | input | 1 | Power-save input |
| sclk | input | 1 | Serial master clock, already sampled into the `clk` domain |
| sdi | input | 1 | Serial data input, also the mode strap at entry |
| sdo | output | 1 | Serial data output of fuse read |
| burnPulse | output | 1 | One-cycle strobe per fuse bit burned |
| opMode | output | 3 | 0 start, 1 normal, 2 fuse read, 3 register write, 4 fuse write |
| cfgWord | output | 52 | Working configuration register |
| offset | output | 8 | XOR-combined offset |
| modeCfg | output | 4 | XOR-combined mode bits |
| errMask | output | 2 | XOR-combined error mask |
| crcSeed | output | 4 | CRC start value |
| testSel | output | 2 | Decoded test selection |

## Verification
A bit counter that is off by one shows up within a single `sclk` edge. It appears as a shifted `cfgWord` after a write session, and as a misaligned bit on `sdo` during a read. A fuse bit that was lost or cleared stays hidden until the next power-up in fuse-read mode, so the bench runs two fuse-write sessions, resets, and reads the fuses back to confirm the OR of both words. A wrong mode decision is visible on `opMode` one clock after reset release. An edge that is accepted after the 52nd bit changes `cfgWord` on the very next edge.

// File: rtl/cfg_shift_pkg.sv
package cfg_shift_pkg;
  localparam int WORD_W   = 52;
  localparam int IDX_W    = $clog2(WORD_W + 1);
  localparam int NUM_SETS = 3;
  localparam int SET_W    = 14;
  localparam int OFS_W    = 8;
  localparam int MODE_W   = 4;
  localparam int ERR_W    = 2;
  localparam int CRC_LSB  = 42;
  localparam int CRC_W    = 4;
  localparam int TEST_LSB = 48;
  localparam int TEST_W   = 4;

  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_NORMAL = 3'd1,
    OP_READ   = 3'd2,
    OP_REGWR  = 3'd3,
    OP_BURN   = 3'd4
  } opMode_e;

  typedef struct packed {
    logic             loadFromFuse;
    logic             writeBit;
    logic             burnBit;
    logic             readActive;
    logic [IDX_W-1:0] bitIdx;
  } strobe_t;
endpackage

// File: rtl/cfg_shift_ctrl.sv
module cfg_shift_ctrl
  import cfg_shift_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    progEn,
  input  logic    burnEn,
  input  logic    psIn,
  input  logic    sclk,
  input  logic    sdi,
  output opMode_e opMode,
  output strobe_t strobe
);
  opMode_e          stateQ, nextState;
  logic             sclkQ;
  logic [IDX_W-1:0] idxQ;
  logic             sclkRise, room, progMode, step;

  assign sclkRise = sclk & ~sclkQ;
  assign room     = (idxQ < IDX_W'(WORD_W));
  assign progMode = (stateQ == OP_READ) || (stateQ == OP_REGWR) || (stateQ == OP_BURN);
  assign step     = sclkRise && room && progMode;

  // mode decision happens exactly once, in the first cycle after reset
  always_comb begin
    nextState = stateQ;
    if (stateQ == OP_START) begin
      if (!progEn || psIn) nextState = OP_NORMAL;
      else if (sdi)        nextState = OP_READ;
      else if (burnEn)     nextState = OP_BURN;
      else                 nextState = OP_REGWR;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= OP_START;
      sclkQ  <= 1'b0;
      idxQ   <= '0;
    end else begin
      stateQ <= nextState;
      sclkQ  <= sclk;
      if (step) idxQ <= idxQ + 1'b1;
    end
  end

  assign opMode              = stateQ;
  assign strobe.loadFromFuse = (stateQ == OP_START);
  assign strobe.writeBit     = step && ((stateQ == OP_REGWR) || (stateQ == OP_BURN));
  assign strobe.burnBit      = step && (stateQ == OP_BURN);
  assign strobe.readActive   = (stateQ == OP_READ) && room;
  assign strobe.bitIdx       = idxQ;
endmodule

// File: rtl/cfg_shift_datapath.sv
module cfg_shift_datapath
  import cfg_shift_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              blankN,
  input  logic              sdi,
  input  strobe_t           strobe,
  output logic [WORD_W-1:0] cfgWord,
  output logic              sdo,
  output logic              burnPulse,
  output logic [OFS_W-1:0]  offset,
  output logic [MODE_W-1:0] modeCfg,
  output logic [ERR_W-1:0]  errMask,
  output logic [CRC_W-1:0]  crcSeed,
  output logic [1:0]        testSel
);
  logic [WORD_W-1:0] fuseQ;
  logic [WORD_W-1:0] cfgQ;
  logic              burnQ;
  logic [TEST_W-1:0] testCode;

  // fuse model: one-way bits, cleared only by the blanking input
  always_ff @(posedge clk or negedge blankN) begin
    if (!blankN) fuseQ <= '0;
    else if (strobe.burnBit && sdi) fuseQ[strobe.bitIdx] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ  <= '0;
      burnQ <= 1'b0;
    end else begin
      burnQ <= strobe.burnBit && sdi;
      if (strobe.loadFromFuse)  cfgQ <= fuseQ;
      else if (strobe.writeBit) cfgQ[strobe.bitIdx] <= sdi;
    end
  end

  assign cfgWord   = cfgQ;
  assign burnPulse = burnQ;
  assign sdo       = strobe.readActive ? cfgQ[strobe.bitIdx] : 1'b0;

  always_comb begin
    offset  = '0;
    modeCfg = '0;
    errMask = '0;
    for (int s = 0; s < NUM_SETS; s++) begin
      offset  ^= cfgQ[s*SET_W +: OFS_W];
      modeCfg ^= cfgQ[s*SET_W + OFS_W +: MODE_W];
      errMask ^= cfgQ[s*SET_W + OFS_W + MODE_W +: ERR_W];
    end
  end

  assign crcSeed  = cfgQ[CRC_LSB +: CRC_W];
  assign testCode = cfgQ[TEST_LSB +: TEST_W];

  always_comb begin
    case (testCode)
      4'b1000: testSel = 2'd1;
      4'b1001: testSel = 2'd2;
      4'b1010: testSel = 2'd3;
      default: testSel = 2'd0;
    endcase
  end
endmodule

// File: rtl/cfg_shift_top.sv
module cfg_shift_top
  import cfg_shift_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              blankN,
  input  logic              progEn,
  input  logic              burnEn,
  input  logic              psIn,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              burnPulse,
  output logic [2:0]        opMode,
  output logic [WORD_W-1:0] cfgWord,
  output logic [OFS_W-1:0]  offset,
  output logic [MODE_W-1:0] modeCfg,
  output logic [ERR_W-1:0]  errMask,
  output logic [CRC_W-1:0]  crcSeed,
  output logic [1:0]        testSel
);
  opMode_e modeInt;
  strobe_t strobe;

  cfg_shift_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .progEn(progEn), .burnEn(burnEn), .psIn(psIn),
    .sclk(sclk), .sdi(sdi), .opMode(modeInt), .strobe(strobe)
  );

  cfg_shift_datapath dp_i (
    .clk(clk), .rstN(rstN), .blankN(blankN), .sdi(sdi), .strobe(strobe),
    .cfgWord(cfgWord), .sdo(sdo), .burnPulse(burnPulse), .offset(offset),
    .modeCfg(modeCfg), .errMask(errMask), .crcSeed(crcSeed), .testSel(testSel)
  );

  assign opMode = modeInt;
endmodule

// File: rtl/cfg_shift_chk.sv
module cfg_shift_chk (
  input logic        clk,
  input logic        rstN,
  input logic        sdo,
  input logic        burnPulse,
  input logic [2:0]  opMode,
  input logic [51:0] cfgWord
);
  p_leave_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (opMode == 3'd0) |=> (opMode != 3'd0));

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(opMode) != 3'd0) |-> (opMode == $past(opMode)));

  p_burn_in_mode_r5: assert property (@(posedge clk) disable iff (!rstN)
    burnPulse |-> (opMode == 3'd4));

  p_burn_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    burnPulse |=> !burnPulse);

  p_sdo_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (opMode != 3'd2) |-> !sdo);

  p_normal_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (opMode == 3'd1 && $past(opMode) == 3'd1) |-> $stable(cfgWord));
endmodule

bind cfg_shift_top cfg_shift_chk chk_i (
  .clk(clk), .rstN(rstN), .sdo(sdo), .burnPulse(burnPulse),
  .opMode(opMode), .cfgWord(cfgWord)
);

// File: tb/cfg_shift_top_tb_top.sv
module cfg_shift_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN, blankN, progEn, burnEn, psIn, sclk, sdi;
  logic sdo, burnPulse;
  logic [2:0]  opMode;
  logic [51:0] cfgWord;
  logic [7:0]  offset;
  logic [3:0]  modeCfg;
  logic [1:0]  errMask, testSel;
  logic [3:0]  crcSeed;

  int checks = 0, errors = 0, burnCnt = 0, cycles = 0;
  logic [51:0] fuseModel = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_shift_top dut_i (.*);

  always @(negedge clk) if (burnPulse) burnCnt++;

  function automatic logic [7:0] expOffset(logic [51:0] w);
    return w[7:0] ^ w[21:14] ^ w[35:28];
  endfunction
  function automatic logic [3:0] expMode(logic [51:0] w);
    return w[11:8] ^ w[25:22] ^ w[39:36];
  endfunction
  function automatic logic [1:0] expErr(logic [51:0] w);
    return w[13:12] ^ w[27:26] ^ w[41:40];
  endfunction
  function automatic logic [1:0] expTest(logic [51:0] w);
    if (w[51:48] == 4'b1000) return 2'd1;
    if (w[51:48] == 4'b1001) return 2'd2;
    if (w[51:48] == 4'b1010) return 2'd3;
    return 2'd0;
  endfunction
  function automatic logic [51:0] randWord();
    return {$urandom, $urandom};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic powerUp(input logic pe, input logic be, input logic ps, input logic si);
    @(negedge clk);
    rstN = 1'b0; progEn = pe; burnEn = be; psIn = ps; sdi = si; sclk = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    sdi = 1'b0;
  endtask

  task automatic pulse(input logic b);
    @(negedge clk);
    sdi = b; sclk = 1'b1;
    repeat (2) @(negedge clk);
    sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic writeWord(input logic [51:0] w);
    for (int k = 0; k < 52; k++) pulse(w[k]);
  endtask

  task automatic readAndCheck(input logic [51:0] exp, input string req);
    int bad = 0;
    powerUp(1'b1, 1'b0, 1'b0, 1'b1);
    check("R2 fuse read mode", opMode, 3'd2);
    check("R3 load at read entry", cfgWord, exp);
    for (int k = 0; k < 52; k++) begin
      if (sdo !== exp[k]) begin
        bad++;
        $display("FAIL %s R6 bit %0d actual=%b expected=%b", req, k, sdo, exp[k]);
      end
      pulse(1'b0);
    end
    checks++;
    if (bad != 0) errors++;
    check("R6 sdo low after last bit", sdo, 1'b0);
  endtask

  task automatic regWriteCheck(input logic [51:0] w);
    powerUp(1'b1, 1'b0, 1'b0, 1'b0);
    check("R2 register write mode", opMode, 3'd3);
    writeWord(w);
    check("R4 register word", cfgWord, w);
    check("R8 offset", offset, expOffset(w));
    check("R8 mode", modeCfg, expMode(w));
    check("R8 error mask", errMask, expErr(w));
    check("R9 crc seed", crcSeed, w[45:42]);
    check("R9 test select", testSel, expTest(w));
  endtask

  initial begin
    while (cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [51:0] a, b, c, w;
    void'($urandom(32'h5eed_0042));
    rstN = 1'b0; blankN = 1'b0; progEn = 1'b0; burnEn = 1'b0;
    psIn = 1'b0; sclk = 1'b0; sdi = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset mode", opMode, 3'd0);
    check("R1 reset word", cfgWord, 52'd0);
    check("R1 reset sdo", sdo, 1'b0);
    check("R1 reset burn", burnPulse, 1'b0);
    blankN = 1'b1;

    powerUp(1'b0, 1'b0, 1'b0, 1'b0);
    check("R2 normal without supply", opMode, 3'd1);
    check("R3 normal load", cfgWord, fuseModel);
    pulse(1'b1); pulse(1'b1);
    check("R7 normal ignores clocks", cfgWord, fuseModel);
    check("R6 sdo low in normal", sdo, 1'b0);
    powerUp(1'b1, 1'b1, 1'b1, 1'b1);
    check("R2 power-save forces normal", opMode, 3'd1);

    a = randWord();
    powerUp(1'b1, 1'b1, 1'b0, 1'b0);
    check("R2 fuse write mode", opMode, 3'd4);
    burnCnt = 0;
    writeWord(a);
    check("R5 fuse write word", cfgWord, a);
    check("R5 burn pulse count", burnCnt, $countones(a));
    fuseModel |= a;
    pulse(~a[0]); pulse(1'b1); pulse(1'b1);
    check("R7 extra clocks ignored", cfgWord, a);
    check("R7 no burns after end", burnCnt, $countones(a));
    readAndCheck(fuseModel, "first burn");

    b = randWord();
    powerUp(1'b1, 1'b1, 1'b0, 1'b0);
    writeWord(b);
    fuseModel |= b;
    readAndCheck(fuseModel, "R5 second burn ORs");

    c = ~fuseModel;
    regWriteCheck(c);
    pulse(1'b1); pulse(1'b0);
    check("R7 register extra clocks", cfgWord, c);
    readAndCheck(fuseModel, "R4 fuses untouched");

    foreach (w[i]) w[i] = 1'b0;
    w[51:48] = 4'b1000; regWriteCheck(w);
    w[51:48] = 4'b1001; regWriteCheck(w);
    w[51:48] = 4'b1010; regWriteCheck(w);
    w[51:48] = 4'b1011; regWriteCheck(w);
    w[51:48] = 4'b0111; regWriteCheck(w);
    w = 52'hF_FFFF_FFFF_FFFF; regWriteCheck(w);
    for (int n = 0; n < 6; n++) regWriteCheck(randWord());

    @(negedge clk);
    blankN = 1'b0;
    @(negedge clk);
    blankN = 1'b1;
    fuseModel = '0;
    readAndCheck(fuseModel, "R10 blank clears fuses");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule